// File: doc/BRIEF.md
# Condition Code Register Update Unit

This block keeps the eight-bit condition code register of a small accumulator-based processor. Each cycle it receives the class of the instruction that has just executed, along with the ALU result and the ALU's carry, overflow and half-carry outputs. From these it works out the next register value. Each instruction class has its own set of flags that it may change. The bits outside that set keep their value.

A separate class loads the whole register directly from a data word. This path serves restores from the stack and transfers from the accumulator. On this path the non-maskable interrupt mask can be cleared but never set. The register value is always visible on one output bus. Decoding instructions and computing ALU results are done elsewhere.

Top module: `ccr_update`

## Requirements
- R1: The bit layout from bit 7 down to bit 0 is S (stop disable), X (non-maskable interrupt mask), H (half carry), I (interrupt mask), N, Z, V, C. After reset the register reads 8'hD0, which means S, X and I are set and all other bits are clear.
- R2: Class code 0 (push, pull, index add, transfer/exchange) leaves every bit unchanged, whatever is on the ALU and write-data inputs. Unused codes 6 and 7 behave the same way.
- R3: Class code 1 (load/store) sets N to bit 7 of the result and sets Z when all result bits are zero. It clears V and leaves C, H, I, X and S unchanged.
- R4: Class code 2 (arithmetic) loads C from the carry/borrow input, V from the overflow input and H from the half-carry input. It updates N and Z from the result and leaves S, X and I unchanged.
- R5: Class code 3 (multiply/divide) loads C from the carry input, which acts as the error indicator. It updates Z from the result and leaves every other bit unchanged.
- R6: Class code 4 (shift/rotate) loads C from the carry input, which carries the bit shifted out. It updates N and Z from the result, sets V to N XOR the new C, and leaves H, I, X and S unchanged.
- R7: Class code 5 (direct write) loads all eight bits from the write-data input, with one exception: X becomes 1 only if it was already 1. The ALU inputs have no effect in this class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Instruction class code |
| res_i | input | DATA_W | ALU result |
| carry_i | input | 1 | ALU carry/borrow, shift-out bit, or mul/div error |
| ovf_i | input | 1 | ALU signed overflow |
| half_i | input | 1 | ALU carry out of bit 3 |
| wr_data_i | input | 8 | Direct-write value |
| ccr_o | output | 8 | Current register value |

## Verification
Any wrong bit in this block shows up on `ccr_o` one cycle after the instruction class that produced it. No further stimulus is needed to expose it. A mask error, where a class changes a bit it should preserve, stays visible until some later class rewrites that bit. The tests therefore set bits to non-default values first and then apply each class, so that preserved bits can be told apart from recomputed ones. The X bit can only be cleared, so the write tests clear it and then try to set it again.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [2:0] {
        OP_KEEP   = 3'd0,
        OP_LDST   = 3'd1,
        OP_ARITH  = 3'd2,
        OP_MULDIV = 3'd3,
        OP_SHIFT  = 3'd4,
        OP_WRITE  = 3'd5
    } ccr_op_e;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam ccr_t CCR_RESET = '{s: 1'b1, x: 1'b1, h: 1'b0, i: 1'b1,
                                   n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/ccr_result_flags.sv
module ccr_result_flags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    output logic              neg_o,
    output logic              zero_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        neg_o  = res_i[MSB];
        zero_o = (res_i == '0);
    end
endmodule

// File: rtl/ccr_wr_filter.sv
module ccr_wr_filter
    import ccr_pkg::*;
(
    input  ccr_t cur_i,
    input  ccr_t wr_i,
    output ccr_t out_o
);
    always_comb begin
        out_o   = wr_i;
        // the non-maskable mask may be released by software but never re-armed
        out_o.x = wr_i.x & cur_i.x;
    end
endmodule

// File: rtl/ccr_update.sv
module ccr_update
    import ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic              half_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        ccr_o
);
    ccr_t ccr_d, ccr_q, wr_filt;
    logic neg, zero;

    ccr_result_flags #(.DATA_W(DATA_W)) i_flags (
        .res_i (res_i),
        .neg_o (neg),
        .zero_o(zero)
    );

    ccr_wr_filter i_wr_filter (
        .cur_i(ccr_q),
        .wr_i (ccr_t'(wr_data_i)),
        .out_o(wr_filt)
    );

    always_comb begin
        ccr_d = ccr_q;
        case (op_i)
            OP_LDST: begin
                ccr_d.n = neg;
                ccr_d.z = zero;
                ccr_d.v = 1'b0;
            end
            OP_ARITH: begin
                ccr_d.h = half_i;
                ccr_d.n = neg;
                ccr_d.z = zero;
                ccr_d.v = ovf_i;
                ccr_d.c = carry_i;
            end
            OP_MULDIV: begin
                ccr_d.z = zero;
                ccr_d.c = carry_i;
            end
            OP_SHIFT: begin
                ccr_d.n = neg;
                ccr_d.z = zero;
                ccr_d.c = carry_i;
                ccr_d.v = neg ^ carry_i;
            end
            OP_WRITE: ccr_d = wr_filt;
            default:  ccr_d = ccr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ccr_q <= CCR_RESET;
        else        ccr_q <= ccr_d;
    end

    assign ccr_o = ccr_q;
endmodule

// File: rtl/ccr_update_chk.sv
module ccr_update_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] res_i,
    input logic              carry_i,
    input logic [7:0]        ccr_o
);
    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i >= 3'd6) |=> ccr_o == $past(ccr_o));

    p_ldst_vclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd1 |=> !ccr_o[1] && ccr_o[0] == $past(ccr_o[0]));

    p_arith_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd2 |=> ccr_o[0] == $past(carry_i));

    p_muldiv_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd3 |=> ccr_o[0] == $past(carry_i) && ccr_o[3] == $past(ccr_o[3]));

    p_shift_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd4 |=> ccr_o[2] == ($past(res_i) == '0));

    p_x_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_o[6] |=> !ccr_o[6]);
endmodule

bind ccr_update ccr_update_chk #(.DATA_W(DATA_W)) i_ccr_update_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .res_i  (res_i),
    .carry_i(carry_i),
    .ccr_o  (ccr_o)
);

// File: tb/test_ccr_update.sv
module test_ccr_update;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op;
    logic [7:0] res, wr;
    logic       cy, ov, hf;
    logic [7:0] ccr;
    int         n_run  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccr_update #(.DATA_W(8)) i_ccr_update (
        .clk(clk), .rst_n(rst_n), .op_i(op), .res_i(res), .carry_i(cy),
        .ovf_i(ov), .half_i(hf), .wr_data_i(wr), .ccr_o(ccr)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        n_run++;
        if (ccr !== exp) begin
            n_fail++;
            $display("FAIL %s: ccr=%h expected %h", tag, ccr, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [7:0] r, input logic c,
                        input logic v, input logic h, input logic [7:0] w,
                        input string tag, input logic [7:0] exp);
        @(negedge clk);
        op = o; res = r; cy = c; ov = v; hf = h; wr = w;
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op = 3'd0; res = 8'h00; cy = 1'b0; ov = 1'b0; hf = 1'b0; wr = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset value", 8'hD0);
    endtask

    task automatic t_ldst();
        step(3'd1, 8'h00, 1'b1, 1'b1, 1'b1, 8'hFF, "R3 load zero", 8'hD4);
        step(3'd1, 8'h80, 1'b1, 1'b1, 1'b1, 8'hFF, "R3 load negative", 8'hD8);
    endtask

    task automatic t_arith();
        step(3'd2, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, "R4 carry ovf half zero", 8'hF7);
        step(3'd2, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h00, "R4 all clear", 8'hD0);
    endtask

    task automatic t_keep();
        step(3'd2, 8'h80, 1'b1, 1'b1, 1'b0, 8'h00, "R4 neg carry ovf", 8'hDB);
        step(3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R2 keep class", 8'hDB);
        step(3'd7, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R2 unused code 7", 8'hDB);
        step(3'd6, 8'h01, 1'b0, 1'b0, 1'b1, 8'h24, "R2 unused code 6", 8'hDB);
    endtask

    task automatic t_muldiv();
        step(3'd3, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, "R5 zero no error", 8'hDE);
        step(3'd3, 8'h05, 1'b1, 1'b0, 1'b1, 8'h00, "R5 error flag", 8'hDB);
    endtask

    task automatic t_shift();
        step(3'd4, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, "R6 shift out one", 8'hD7);
        step(3'd4, 8'h81, 1'b0, 1'b1, 1'b1, 8'h00, "R6 shift neg no carry", 8'hDA);
    endtask

    task automatic t_write();
        step(3'd5, 8'hFF, 1'b1, 1'b1, 1'b1, 8'h00, "R7 write clear all", 8'h00);
        step(3'd5, 8'h00, 1'b0, 1'b0, 1'b0, 8'hFF, "R7 write ones X held", 8'hBF);
        step(3'd5, 8'hFF, 1'b1, 1'b1, 1'b1, 8'h40, "R7 X cannot be set", 8'h00);
    endtask

    initial begin
        t_reset();
        t_ldst();
        t_arith();
        t_keep();
        t_muldiv();
        t_shift();
        t_write();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule